// File: doc/BRIEF.md
# Gated Multi-Mode Clock Divider Slice

This block produces one derived clock for one peripheral. It picks one of two source inputs: a slow reference or a fast PLL output. It divides that source by a ratio taken from a programmable field, and it gates the result with an enable bit. Each source is modelled as a tick: a one-cycle enable pulse on the fast system clock `clk_i`, so one tick stands for one edge of that source. All logic is synchronous to `clk_i`. The divided clock leaves the block as the level `clk_o`, and `rate_stb_o` pulses for one cycle at the start of every output period. The `MODE` parameter sets how the field is turned into a ratio. One mode turns the slice into a system bus clock stage, with a reference bypass and a power-of-two divide.

A configuration word written through `cfg_we_i`/`cfg_wdata_i` holds three things: the enable bit, the select bit and the divider field. Their positions are set by parameters, and any of the enable and select bits can be left out. Changes are handled by a five-state controller:

- PARKED: no output.
- ACTIVE: dividing.
- DRAINING: finishing the current output period after the enable was cleared or the select changed.
- SYNC_A, then SYNC_B: two cycles of handshake.

The transitions are as follows:

- PARKED goes to SYNC_A when the enable is set.
- ACTIVE goes to DRAINING when the enable drops or the requested source differs from the active one.
- DRAINING goes to SYNC_A once the divider is stopped.
- SYNC_A always goes to SYNC_B.
- SYNC_B goes to ACTIVE if the enable is set, and loads the requested source. Otherwise it goes to PARKED.

Top module: `clkdiv_slice`

## Requirements
- R1: With `MODE` set to plus-one, the divide ratio is n+1, where n is the `DIV_W`-bit field at bit offset `DIV_OFF` of the configuration word.
- R2: With `MODE` set to twice, the divide ratio is 2*(n+1).
- R3: With `MODE` set to power-of-two, the divide ratio is 2 shifted left by n, that is 2^(n+1).
- R4: With `MODE` set to bus stage, a select of 0 passes the reference ticks through undivided (ratio 1). A select of 1 divides the PLL ticks by 2 shifted left by the 2-bit field, giving 2, 4, 8 or 16.
- R5: For a ratio N of 2 or more, `clk_o` is high for floor(N/2) source ticks and low for the rest of the N ticks. For N = 1 it stays high. `rate_stb_o` is high for one `clk_i` cycle at the start of each period, in the same cycle that `clk_o` starts the high phase.
- R6: During and after reset, `clk_o`, `rate_stb_o` and `src_pll_o` are 0. The configuration word resets to all zeros.
- R7: With `HAS_GATE` set, setting the enable bit (bit `GATE_BIT`) starts the output. Clearing it lets the current period finish in full, then holds `clk_o` low with no strobes. Without a gate, the slice always runs.
- R8: With `HAS_MUX` set, select bit `MUX_BIT` = 0 chooses the reference ticks and 1 chooses the PLL ticks. `src_pll_o` shows the active source. Without a mux, the reference is always used and `src_pll_o` stays 0.
- R9: A new ratio written in the middle of a period takes effect only when the next period starts, so the current period keeps its old length.
- R10: On a source change, the old source finishes its current period, `clk_o` stays low for at least three `clk_i` cycles, and only then does `src_pll_o` change. The next period then runs on the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the source ticks |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One pulse per edge of the reference source |
| pll_tick_i | input | 1 | One pulse per edge of the PLL source |
| cfg_we_i | input | 1 | Write strobe for the configuration word |
| cfg_wdata_i | input | REG_W | Configuration word holding the enable, select and divider field |
| clk_o | output | 1 | Divided, gated clock level |
| rate_stb_o | output | 1 | One-cycle pulse at the start of each output period |
| src_pll_o | output | 1 | Active source: 1 for PLL, 0 for reference |

## Verification
Four slices with different modes, field widths and bit layouts are each tried with the smallest field, mid-range fields and the largest field, on both sources. Matching the period against a high-time count separates a wrong ratio formula from a wrong duty rule. Running the same field on the reference (two cycles per tick) and on the PLL (one cycle per tick) shows whether the selected tick stream is the one being counted. Directed sequences then change the ratio, clear the enable and flip the source in the middle of a period. These show whether the current period is cut short and whether the switch leaves a low gap before the new source.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    // Ratio encodings a slice can be built with.
    typedef enum logic [1:0] {
        RATIO_PLUS1 = 2'd0,   // n + 1
        RATIO_TWICE = 2'd1,   // 2 * (n + 1)
        RATIO_POW2  = 2'd2,   // 2 << n
        RATIO_BUS   = 2'd3    // bypass on reference, 2 << n on PLL
    } ratio_mode_e;

    // Source-switch and gating controller states.
    typedef enum logic [2:0] {
        SL_PARKED   = 3'd0,
        SL_ACTIVE   = 3'd1,
        SL_DRAINING = 3'd2,
        SL_SYNC_A   = 3'd3,
        SL_SYNC_B   = 3'd4
    } slice_state_e;

    // Counter width able to hold the largest ratio of a mode.
    function automatic int ratio_cnt_width(ratio_mode_e mode, int field_w);
        if (mode == RATIO_POW2 || mode == RATIO_BUS) begin
            return (1 << field_w) + 1;
        end
        return field_w + 2;
    endfunction

endpackage

// File: rtl/clkdiv_cfg_reg.sv
`timescale 1ns/1ps
module clkdiv_cfg_reg #(
    parameter int REG_W    = 32,
    parameter int DIV_W    = 4,
    parameter int DIV_OFF  = 8,
    parameter bit HAS_GATE = 1'b1,
    parameter int GATE_BIT = 0,
    parameter bit HAS_MUX  = 1'b1,
    parameter int MUX_BIT  = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic             gate_o,
    output logic             sel_o,
    output logic [DIV_W-1:0] field_o
);

    logic [DIV_W-1:0] field_q;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            field_q <= '0;
        end else if (we_i) begin
            field_q <= wdata_i[DIV_OFF +: DIV_W];
        end
    end

    assign field_o = field_q;

    generate
        if (HAS_GATE) begin : g_gate
            logic gate_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    gate_q <= 1'b0;
                end else if (we_i) begin
                    gate_q <= wdata_i[GATE_BIT];
                end
            end
            assign gate_o = gate_q;
        end else begin : g_no_gate
            assign gate_o = 1'b1;
        end

        if (HAS_MUX) begin : g_mux
            logic sel_q;
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    sel_q <= 1'b0;
                end else if (we_i) begin
                    sel_q <= wdata_i[MUX_BIT];
                end
            end
            assign sel_o = sel_q;
        end else begin : g_no_mux
            assign sel_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_ratio_decode.sv
`timescale 1ns/1ps
module clkdiv_ratio_decode
    import clkdiv_pkg::*;
#(
    parameter ratio_mode_e MODE  = RATIO_PLUS1,
    parameter int          DIV_W = 4,
    parameter int          CNT_W = ratio_cnt_width(MODE, DIV_W)
) (
    input  logic [DIV_W-1:0] field_i,
    input  logic             src_pll_i,
    output logic [CNT_W-1:0] ratio_o
);

    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO_C = CNT_W'(2);

    logic [CNT_W-1:0] field_ext;
    assign field_ext = {{(CNT_W-DIV_W){1'b0}}, field_i};

    generate
        if (MODE == RATIO_PLUS1) begin : g_plus1
            logic unused_src;
            assign unused_src = src_pll_i;
            assign ratio_o    = field_ext + ONE_C;
        end else if (MODE == RATIO_TWICE) begin : g_twice
            logic unused_src;
            assign unused_src = src_pll_i;
            assign ratio_o    = (field_ext + ONE_C) << 1;
        end else if (MODE == RATIO_POW2) begin : g_pow2
            logic unused_src;
            assign unused_src = src_pll_i;
            assign ratio_o    = TWO_C << field_i;
        end else begin : g_bus
            // Reference is bypassed; the PLL path takes a power-of-two divide.
            assign ratio_o = src_pll_i ? (TWO_C << field_i) : ONE_C;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_counter.sv
`timescale 1ns/1ps
module clkdiv_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] ratio_i,
    output logic             clk_o,
    output logic             stb_o,
    output logic             idle_o
);

    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] half_w;
    logic             at_end;
    logic             clk_q;
    logic             stb_q;
    logic             idle_q;

    assign cnt_inc = cnt_q + ONE_C;
    assign at_end  = (cnt_inc == act_q);
    assign half_w  = (act_q == ONE_C) ? ONE_C : (act_q >> 1);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            act_q  <= ONE_C;
            clk_q  <= 1'b0;
            stb_q  <= 1'b0;
            idle_q <= 1'b1;
        end else begin
            stb_q <= 1'b0;
            if (!run_i) begin
                cnt_q  <= '0;
                clk_q  <= 1'b0;
                idle_q <= 1'b1;
            end else if (tick_i) begin
                if (!stop_i && (idle_q || at_end)) begin
                    // Period start: the ratio is reloaded only here.
                    cnt_q  <= '0;
                    act_q  <= ratio_i;
                    clk_q  <= 1'b1;
                    stb_q  <= 1'b1;
                    idle_q <= 1'b0;
                end else if (idle_q) begin
                    cnt_q <= '0;
                end else if (at_end) begin
                    // Stop request honoured only at a full period boundary.
                    cnt_q  <= '0;
                    clk_q  <= 1'b0;
                    idle_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                    clk_q <= (cnt_inc < half_w);
                end
            end
        end
    end

    assign clk_o  = clk_q;
    assign stb_o  = stb_q;
    assign idle_o = idle_q;

    // R5: a strobe always coincides with the output high phase.
    p_stb_in_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb_q |-> clk_q);

    // R9: the count never runs past the ratio latched for the period.
    p_cnt_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !idle_q |-> (cnt_q < act_q));

    // R9: the active ratio changes only together with a period-start strobe.
    p_reload_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_q) |-> stb_q);

    // R7: a stopped divider drives a low output.
    p_idle_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        idle_q |-> !clk_q);

endmodule

// File: rtl/clkdiv_switch_fsm.sv
`timescale 1ns/1ps
module clkdiv_switch_fsm
    import clkdiv_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gate_i,
    input  logic sel_i,
    input  logic core_idle_i,
    output logic run_o,
    output logic stop_o,
    output logic src_pll_o
);

    slice_state_e state_q;
    slice_state_e state_d;
    logic         src_q;

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SL_PARKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Active source is loaded only on the handshake exit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_q <= 1'b0;
        end else if (state_q == SL_SYNC_B && gate_i) begin
            src_q <= sel_i;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_PARKED:   if (gate_i) state_d = SL_SYNC_A;
            SL_ACTIVE:   if (!gate_i || (sel_i != src_q)) state_d = SL_DRAINING;
            SL_DRAINING: if (core_idle_i) state_d = SL_SYNC_A;
            SL_SYNC_A:   state_d = SL_SYNC_B;
            SL_SYNC_B:   state_d = gate_i ? SL_ACTIVE : SL_PARKED;
            default:     state_d = SL_PARKED;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        run_o  = 1'b0;
        stop_o = 1'b0;
        unique case (state_q)
            SL_ACTIVE:   run_o = 1'b1;
            SL_DRAINING: begin
                run_o  = 1'b1;
                stop_o = 1'b1;
            end
            SL_PARKED, SL_SYNC_A, SL_SYNC_B: run_o = 1'b0;
            default:     run_o = 1'b0;
        endcase
    end

    assign src_pll_o = src_q;

    // R10: the source flips only when leaving the second handshake state.
    p_src_after_sync_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(src_q) |-> ($past(state_q) == SL_SYNC_B));

    // R7, R10: the divider is stopped whenever the slice is parked or syncing.
    p_parked_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SL_PARKED || state_q == SL_SYNC_A || state_q == SL_SYNC_B)
            |-> core_idle_i);

    // R10: draining holds until the divider reports a completed period.
    p_drain_waits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SL_DRAINING && !core_idle_i) |=> (state_q == SL_DRAINING));

endmodule

// File: rtl/clkdiv_slice.sv
`timescale 1ns/1ps
module clkdiv_slice
    import clkdiv_pkg::*;
#(
    parameter ratio_mode_e MODE     = RATIO_PLUS1,
    parameter int          REG_W    = 32,
    parameter int          DIV_W    = 4,
    parameter int          DIV_OFF  = 8,
    parameter bit          HAS_GATE = 1'b1,
    parameter int          GATE_BIT = 0,
    parameter bit          HAS_MUX  = 1'b1,
    parameter int          MUX_BIT  = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ref_tick_i,
    input  logic             pll_tick_i,
    input  logic             cfg_we_i,
    input  logic [REG_W-1:0] cfg_wdata_i,
    output logic             clk_o,
    output logic             rate_stb_o,
    output logic             src_pll_o
);

    localparam int CNT_W = ratio_cnt_width(MODE, DIV_W);

    logic             gate_w;
    logic             sel_w;
    logic [DIV_W-1:0] field_w;
    logic [CNT_W-1:0] ratio_w;
    logic             src_pll_w;
    logic             run_w;
    logic             stop_w;
    logic             idle_w;
    logic             tick_w;

    clkdiv_cfg_reg #(
        .REG_W(REG_W), .DIV_W(DIV_W), .DIV_OFF(DIV_OFF),
        .HAS_GATE(HAS_GATE), .GATE_BIT(GATE_BIT),
        .HAS_MUX(HAS_MUX), .MUX_BIT(MUX_BIT)
    ) u_cfg (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
        .gate_o(gate_w), .sel_o(sel_w), .field_o(field_w)
    );

    clkdiv_ratio_decode #(.MODE(MODE), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_dec (
        .field_i(field_w), .src_pll_i(src_pll_w), .ratio_o(ratio_w)
    );

    clkdiv_switch_fsm u_fsm (
        .clk_i(clk_i), .rst_ni(rst_ni), .gate_i(gate_w), .sel_i(sel_w),
        .core_idle_i(idle_w), .run_o(run_w), .stop_o(stop_w), .src_pll_o(src_pll_w)
    );

    assign tick_w = src_pll_w ? pll_tick_i : ref_tick_i;

    clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_w), .run_i(run_w),
        .stop_i(stop_w), .ratio_i(ratio_w),
        .clk_o(clk_o), .stb_o(rate_stb_o), .idle_o(idle_w)
    );

    assign src_pll_o = src_pll_w;

    // R5: every period start is caused by a tick of the active source.
    p_stb_after_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rate_stb_o |-> $past(tick_w));

    // R8: a slice built without a mux never leaves the reference.
    p_no_mux_ref_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !HAS_MUX |-> !src_pll_o);

endmodule

// File: tb/clkdiv_slice_tb_top.sv
`timescale 1ns/1ps
module clkdiv_slice_tb_top;
    import clkdiv_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  unit;
        logic [31:0] wdata;
        logic [15:0] period;
        logic [15:0] high;
    } vec_t;

    // Periods and high times are in clk cycles: PLL tick every cycle,
    // reference tick every second cycle.
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h0000_0003, 16'd1,    16'd1},    // R1 pll n=0  N=1
        '{2'd0, 32'h0000_0203, 16'd3,    16'd1},    // R1 pll n=2  N=3
        '{2'd0, 32'h0000_0503, 16'd6,    16'd3},    // R1 pll n=5  N=6
        '{2'd0, 32'h0000_0301, 16'd8,    16'd4},    // R1 ref n=3  N=4
        '{2'd0, 32'h0000_0F03, 16'd16,   16'd8},    // R1 pll n=15 N=16
        '{2'd1, 32'h0000_0000, 16'd4,    16'd2},    // R2 ref n=0  N=2
        '{2'd1, 32'h0004_0000, 16'd20,   16'd10},   // R2 ref n=4  N=10
        '{2'd1, 32'h00FF_0000, 16'd1024, 16'd512},  // R2 ref n=255 N=512
        '{2'd2, 32'h0000_0003, 16'd2,    16'd1},    // R3 pll n=0  N=2
        '{2'd2, 32'h0000_0033, 16'd16,   16'd8},    // R3 pll n=3  N=16
        '{2'd2, 32'h0000_0073, 16'd256,  16'd128},  // R3 pll n=7  N=256
        '{2'd2, 32'h0000_0011, 16'd8,    16'd4},    // R3 ref n=1  N=4
        '{2'd3, 32'h0000_0006, 16'd2,    16'd2},    // R4 ref bypass
        '{2'd3, 32'h0000_0001, 16'd2,    16'd1},    // R4 pll f=0  N=2
        '{2'd3, 32'h0000_0003, 16'd4,    16'd2},    // R4 pll f=1  N=4
        '{2'd3, 32'h0000_0007, 16'd16,   16'd8}     // R4 pll f=3  N=16
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        pll_tick = 1'b1;
    logic [31:0] wdata = '0;
    logic [3:0]  we = '0;
    logic [3:0]  ck;
    logic [3:0]  st;
    logic [3:0]  sp;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Unit 0: plus-one, field [11:8], enable bit 0, select bit 1.
    clkdiv_slice #(.MODE(RATIO_PLUS1), .REG_W(32), .DIV_W(4), .DIV_OFF(8),
        .HAS_GATE(1'b1), .GATE_BIT(0), .HAS_MUX(1'b1), .MUX_BIT(1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
        .cfg_we_i(we[0]), .cfg_wdata_i(wdata),
        .clk_o(ck[0]), .rate_stb_o(st[0]), .src_pll_o(sp[0]));

    // Unit 1: twice, field [23:16], no enable, no select.
    clkdiv_slice #(.MODE(RATIO_TWICE), .REG_W(32), .DIV_W(8), .DIV_OFF(16),
        .HAS_GATE(1'b0), .GATE_BIT(0), .HAS_MUX(1'b0), .MUX_BIT(1)) dut_dbl_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
        .cfg_we_i(we[1]), .cfg_wdata_i(wdata),
        .clk_o(ck[1]), .rate_stb_o(st[1]), .src_pll_o(sp[1]));

    // Unit 2: power-of-two, field [6:4], enable bit 0, select bit 1.
    clkdiv_slice #(.MODE(RATIO_POW2), .REG_W(32), .DIV_W(3), .DIV_OFF(4),
        .HAS_GATE(1'b1), .GATE_BIT(0), .HAS_MUX(1'b1), .MUX_BIT(1)) dut_pow_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
        .cfg_we_i(we[2]), .cfg_wdata_i(wdata),
        .clk_o(ck[2]), .rate_stb_o(st[2]), .src_pll_o(sp[2]));

    // Unit 3: bus stage, select bit 0, field [2:1], no enable.
    clkdiv_slice #(.MODE(RATIO_BUS), .REG_W(32), .DIV_W(2), .DIV_OFF(1),
        .HAS_GATE(1'b0), .GATE_BIT(0), .HAS_MUX(1'b1), .MUX_BIT(0)) dut_bus_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .pll_tick_i(pll_tick),
        .cfg_we_i(we[3]), .cfg_wdata_i(wdata),
        .clk_o(ck[3]), .rate_stb_o(st[3]), .src_pll_o(sp[3]));

    initial begin
        forever begin
            @(negedge clk);
            ref_tick = ~ref_tick;
        end
    end

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic string unit_tag(input int u);
        case (u)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic write_cfg(input int u, input logic [31:0] v);
        @(negedge clk);
        wdata = v;
        we[u] = 1'b1;
        @(negedge clk);
        we = '0;
    endtask

    task automatic wait_stb(input int u);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!st[u] && n < 5000);
        if (n >= 5000) check("R5", 0, 1, "strobe seen");
    endtask

    // Called on a strobe sample; returns cycles and high samples up to the next strobe.
    task automatic measure(input int u, output int p, output int h);
        p = 0;
        h = 0;
        do begin
            h += int'(ck[u]);
            p++;
            @(negedge clk);
        end while (!st[u] && p < 5000);
    endtask

    initial begin
        #(CLK_PERIOD * 180000);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int p;
        int h;
        int n;
        int cnt_st;
        logic [2:0] hist;

        // R6: reset state.
        repeat (4) @(negedge clk);
        check("R6", int'(ck), 0, "clk_o during reset");
        check("R6", int'(st), 0, "strobe during reset");
        check("R6", int'(sp), 0, "src during reset");
        rst_n = 1'b1;

        // R7: gated slices stay silent after reset.
        cnt_st = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            cnt_st += int'(st[0]) + int'(st[2]) + int'(ck[0]) + int'(ck[2]);
        end
        check("R7", cnt_st, 0, "gated-off activity after reset");

        // Ratio and duty table.
        for (int i = 0; i < NV; i++) begin
            write_cfg(int'(VECS[i].unit), VECS[i].wdata);
            repeat (3) wait_stb(int'(VECS[i].unit));
            measure(int'(VECS[i].unit), p, h);
            check(unit_tag(int'(VECS[i].unit)), p, int'(VECS[i].period), $sformatf("period vec %0d", i));
            check("R5", h, int'(VECS[i].high), $sformatf("high time vec %0d", i));
        end

        // R8: select reaches the active-source output.
        check("R8", int'(sp[0]), 1, "unit0 on pll");
        check("R8", int'(sp[3]), 1, "bus unit on pll");

        // R8: no-mux slice ignores the select bit position.
        write_cfg(1, 32'h0004_0002);
        repeat (3) wait_stb(1);
        measure(1, p, h);
        check("R8", int'(sp[1]), 0, "no-mux src");
        check("R8", p, 20, "no-mux period stays on reference");

        // R9: reload mid-period keeps the current period length.
        wait_stb(0);
        write_cfg(0, 32'h0000_0103);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!st[0] && n < 100);
        check("R9", n + 2, 16, "period spanning the reload");
        measure(0, p, h);
        check("R9", p, 2, "period after reload");

        // R7: clearing the enable completes the period then stops.
        write_cfg(0, 32'h0000_0F03);
        repeat (3) wait_stb(0);
        h = int'(ck[0]);
        cnt_st = 0;
        for (int i = 1; i < 80; i++) begin
            @(negedge clk);
            if (i == 1) begin
                wdata = 32'h0000_0F02;
                we[0] = 1'b1;
            end else begin
                we = '0;
            end
            h += int'(ck[0]);
            cnt_st += int'(st[0]);
        end
        check("R7", h, 8, "high samples after enable cleared");
        check("R7", cnt_st, 0, "strobes after enable cleared");

        // R7: setting the enable restarts the output.
        write_cfg(0, 32'h0000_0F03);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!st[0] && n < 50);
        check("R7", int'(n < 10), 1, "restart latency below 10 cycles");

        // R10: switch from PLL to reference with a low gap.
        write_cfg(0, 32'h0000_0503);
        repeat (3) wait_stb(0);
        write_cfg(0, 32'h0000_0501);
        hist = {ck[0], ck[0], ck[0]};
        n = 0;
        while (sp[0] && n < 200) begin
            hist = {hist[1:0], ck[0]};
            @(negedge clk);
            n++;
        end
        check("R10", int'(sp[0]), 0, "source switched to reference");
        check("R10", int'({hist, ck[0]}), 0, "output low around the switch");
        repeat (2) wait_stb(0);
        measure(0, p, h);
        check("R10", p, 12, "period on the new source");

        summary();
        $finish;
    end

endmodule